// File: doc/BRIEF.md
# Encoder-Paced Line Trigger Generator

This block turns an incremental quadrature encoder into line timing for a line-scan imager. It decodes the A and B channels at four counts per cycle into a signed position. It also accumulates forward displacement and emits a line-start pulse each time that displacement reaches a programmable count. Line spacing therefore follows the real motion of the target, not a free-running timer.

Each line start passes through a programmable phase delay. It then produces a one-cycle line-valid pulse and a matching TDI shift strobe, which align the line with exposure and charge transfer. A running line counter advances once per issued line, so downstream logic can detect gaps in line continuity.

An optional index input re-anchors position and displacement to zero once per arming. A sticky error flag and a miss counter record illegal encoder transitions. A sticky overrun flag records a crossing that arrives while a delay is still running.

Top module: `enc_line_gen`

## Requirements
- R1: Each legal forward transition of {A,B} along the cycle 00→01→11→10→00 raises `position` by one. The change is visible on the cycle after the clock edge that first samples the new inputs.
- R2: Each legal reverse transition (the same cycle walked backwards) lowers `position` by one. After a reverse step `dir_rev` reads 1, and after a forward step it reads 0.
- R3: A transition in which A and B both change at once leaves `position` unchanged. It sets the sticky `quad_err` and raises `miss_count` by one.
- R4: Forward steps add to an internal displacement count. When that count reaches `line_thresh`, `line_start` pulses for one cycle and the threshold is subtracted from the count.
- R5: Reverse steps subtract from the displacement count. No line starts until forward travel has made up the reversed distance.
- R6: While `idx_en` is 1, the first rising edge of `enc_z` that is sampled with A=1 and B=1 clears both `position` and the displacement count, and sets `idx_seen`. Later Z edges are ignored until `idx_en` is driven low and then high again.
- R7: `line_valid` and `tdi_shift` pulse together for one cycle, exactly `phase_dly`+1 cycles after the `line_start` pulse that caused them.
- R8: `line_count` rises by one in the cycle in which `line_valid` is high, and does not change otherwise.
- R9: A `line_start` that arrives while a delay is running is held and issued `phase_dly`+1 cycles after the current `line_valid`, and the sticky `overrun` flag is set. Only one crossing is held.
- R10: After reset, `position`, `line_count` and `miss_count` read 0, and every pulse output and flag reads 0.
- R11: A `line_thresh` of 0 behaves as a threshold of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder channel A, already synchronized |
| enc_b | input | 1 | Encoder channel B, already synchronized |
| enc_z | input | 1 | Encoder index, already synchronized |
| idx_en | input | 1 | Arms index re-anchoring |
| line_thresh | input | CW | Encoder counts per line |
| phase_dly | input | DW | Cycles of delay from line start to line valid, minus one |
| position | output | PW | Signed position in quadrature counts |
| line_start | output | 1 | Threshold-crossing pulse |
| line_valid | output | 1 | Delayed line pulse |
| tdi_shift | output | 1 | TDI shift strobe, issued with line_valid |
| line_count | output | LW | Issued line count, wraps |
| dir_rev | output | 1 | Direction of the last legal step, 1 = reverse |
| quad_err | output | 1 | Sticky illegal-transition flag |
| miss_count | output | MW | Count of illegal transitions |
| overrun | output | 1 | Sticky flag for a crossing that arrived during a delay |
| idx_seen | output | 1 | Index captured since arming |

## Verification
The assertions assume that the encoder inputs are already synchronized to `clk`. They also assume that `line_thresh` and `phase_dly` stay constant while the encoder is moving. If the threshold were lowered below the current displacement, the count could sit at or above it, and the bound on the displacement count would fail. The stimulus therefore changes configuration only while the block is held in reset. It drives every input on the falling clock edge, and it changes Z only while A and B sit still.

// File: rtl/enc_line_pkg.sv
package enc_line_pkg;

    typedef struct packed {
        logic fwd;
        logic rev;
        logic bad;
    } qstep_t;

    typedef enum logic [0:0] {
        DS_IDLE  = 1'b0,
        DS_COUNT = 1'b1
    } dly_state_e;

    // Gray phase order 00,01,11,10 mapped to 0..3
    function automatic logic [1:0] gray_idx(input logic a, input logic b);
        return {a, a ^ b};
    endfunction

endpackage

// File: rtl/enc_quad_dec.sv
module enc_quad_dec
    import enc_line_pkg::*;
#(
    parameter int MW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a,
    input  logic          b,
    output qstep_t        step,
    output logic          dir_rev,
    output logic          quad_err,
    output logic [MW-1:0] miss_count
);

    logic [1:0] prev_idx;
    logic [1:0] cur_idx;
    logic [1:0] diff;
    logic       primed;

    assign cur_idx = gray_idx(a, b);
    assign diff    = cur_idx - prev_idx;

    always_comb begin
        step = '0;
        if (primed) begin
            case (diff)
                2'd1:    step.fwd = 1'b1;
                2'd3:    step.rev = 1'b1;
                2'd2:    step.bad = 1'b1;
                default: step = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_idx   <= 2'd0;
            primed     <= 1'b0;
            dir_rev    <= 1'b0;
            quad_err   <= 1'b0;
            miss_count <= '0;
        end else begin
            prev_idx <= cur_idx;
            primed   <= 1'b1;
            if (step.fwd) dir_rev <= 1'b0;
            if (step.rev) dir_rev <= 1'b1;
            if (step.bad) begin
                quad_err   <= 1'b1;
                miss_count <= miss_count + 1'b1;
            end
        end
    end

    AST_MISS_INC: assert property (@(posedge clk) disable iff (rst)
        step.bad |=> miss_count == $past(miss_count) + 1'b1); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        quad_err |=> quad_err); // R3
    AST_DIR_REV: assert property (@(posedge clk) disable iff (rst)
        step.rev |=> dir_rev); // R2

endmodule

// File: rtl/enc_line_accum.sv
module enc_line_accum
    import enc_line_pkg::*;
#(
    parameter int CW = 16,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  qstep_t        step,
    input  logic          a,
    input  logic          b,
    input  logic          z,
    input  logic          idx_en,
    input  logic [CW-1:0] thresh,
    output logic [PW-1:0] position,
    output logic          line_start,
    output logic          idx_seen
);

    localparam logic signed [CW:0] ACC_ONE = (CW+1)'(1);
    localparam logic signed [CW:0] ACC_MIN = {1'b1, {CW{1'b0}}};
    localparam logic [PW-1:0]      POS_ONE = PW'(1);

    logic signed [CW:0] acc;
    logic signed [CW:0] acc_up;
    logic signed [CW:0] eff_s;
    logic [CW-1:0]      eff;
    logic               z_prev;
    logic               idx_hit;

    assign eff     = (thresh == '0) ? CW'(1) : thresh;
    assign eff_s   = $signed({1'b0, eff});
    assign acc_up  = acc + ACC_ONE;
    assign idx_hit = idx_en && !idx_seen && z && !z_prev && a && b;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            position   <= '0;
            line_start <= 1'b0;
            idx_seen   <= 1'b0;
            z_prev     <= 1'b0;
        end else begin
            z_prev     <= z;
            line_start <= 1'b0;
            if (idx_hit) begin
                acc      <= '0;
                position <= '0;
                idx_seen <= 1'b1;
            end else begin
                if (!idx_en) idx_seen <= 1'b0;
                if (step.fwd) begin
                    position <= position + POS_ONE;
                    if (acc_up >= eff_s) begin
                        acc        <= acc_up - eff_s;
                        line_start <= 1'b1;
                    end else begin
                        acc <= acc_up;
                    end
                end else if (step.rev) begin
                    position <= position - POS_ONE;
                    if (acc != ACC_MIN) acc <= acc - ACC_ONE;
                end
            end
        end
    end

    AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        idx_hit |=> position == '0); // R6
    AST_IDX_ONCE: assert property (@(posedge clk) disable iff (rst)
        (idx_seen && idx_en) |=> idx_seen); // R6
    // holds while thresh stays constant during motion
    AST_ACC_BELOW: assert property (@(posedge clk) disable iff (rst)
        acc < eff_s); // R4
    AST_POS_MOVE: assert property (@(posedge clk) disable iff (rst)
        (position != $past(position)) |->
            ($past(step.fwd) || $past(step.rev) || $past(idx_hit))); // R1
    AST_LS_FWD: assert property (@(posedge clk) disable iff (rst)
        line_start |-> $past(step.fwd)); // R5

endmodule

// File: rtl/enc_line_delay.sv
module enc_line_delay
    import enc_line_pkg::*;
#(
    parameter int DW = 16,
    parameter int LW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_start,
    input  logic [DW-1:0] dly,
    output logic          line_valid,
    output logic          tdi_shift,
    output logic [LW-1:0] line_count,
    output logic          overrun
);

    dly_state_e    state;
    logic [DW-1:0] cnt;
    logic          pending;
    logic          busy;
    logic          fire;

    assign busy = (state == DS_COUNT);
    assign fire = (busy && cnt == '0) ||
                  (!busy && line_start && dly == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= DS_IDLE;
            cnt        <= '0;
            pending    <= 1'b0;
            line_valid <= 1'b0;
            tdi_shift  <= 1'b0;
            line_count <= '0;
            overrun    <= 1'b0;
        end else begin
            line_valid <= fire;
            tdi_shift  <= fire;
            if (fire) line_count <= line_count + 1'b1;
            if (busy && line_start) overrun <= 1'b1;
            case (state)
                DS_IDLE: begin
                    if (line_start && dly != '0) begin
                        state <= DS_COUNT;
                        cnt   <= dly - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        if (pending || line_start) begin
                            cnt     <= dly;
                            pending <= pending && line_start;
                        end else begin
                            state <= DS_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                        if (line_start) pending <= 1'b1;
                    end
                end
            endcase
        end
    end

    AST_VALID_SRC: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> ($past(busy) || ($past(line_start) && $past(dly) == '0))); // R7
    AST_CNT_INC: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> line_count == $past(line_count) + 1'b1); // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !line_valid |-> $stable(line_count)); // R8
    AST_PEND_BUSY: assert property (@(posedge clk) disable iff (rst)
        pending |-> busy); // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R9

endmodule

// File: rtl/enc_line_gen.sv
module enc_line_gen
    import enc_line_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 16,
    parameter int PW = 32,
    parameter int LW = 32,
    parameter int MW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enc_a,
    input  logic          enc_b,
    input  logic          enc_z,
    input  logic          idx_en,
    input  logic [CW-1:0] line_thresh,
    input  logic [DW-1:0] phase_dly,
    output logic [PW-1:0] position,
    output logic          line_start,
    output logic          line_valid,
    output logic          tdi_shift,
    output logic [LW-1:0] line_count,
    output logic          dir_rev,
    output logic          quad_err,
    output logic [MW-1:0] miss_count,
    output logic          overrun,
    output logic          idx_seen
);

    qstep_t step;

    enc_quad_dec #(.MW(MW)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .a          (enc_a),
        .b          (enc_b),
        .step       (step),
        .dir_rev    (dir_rev),
        .quad_err   (quad_err),
        .miss_count (miss_count)
    );

    enc_line_accum #(.CW(CW), .PW(PW)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .a          (enc_a),
        .b          (enc_b),
        .z          (enc_z),
        .idx_en     (idx_en),
        .thresh     (line_thresh),
        .position   (position),
        .line_start (line_start),
        .idx_seen   (idx_seen)
    );

    enc_line_delay #(.DW(DW), .LW(LW)) u_dly (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .dly        (phase_dly),
        .line_valid (line_valid),
        .tdi_shift  (tdi_shift),
        .line_count (line_count),
        .overrun    (overrun)
    );

endmodule

// File: tb/tb_enc_line_gen.sv
module tb_enc_line_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0, idx_en = 1'b0;
    logic [15:0] line_thresh = 16'd8;
    logic [15:0] phase_dly = 16'd0;
    logic [31:0] position;
    logic        line_start, line_valid, tdi_shift;
    logic [31:0] line_count;
    logic        dir_rev, quad_err, overrun, idx_seen;
    logic [15:0] miss_count;

    int total = 0, bad = 0;
    int cyc = 0, ls_cnt = 0, lv_cnt = 0, ts_cnt = 0;
    int ls_cyc = 0, lv_cyc = 0, lv_prev = 0;
    bit done = 0;

    always #10 clk = ~clk;

    enc_line_gen dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
        .idx_en(idx_en), .line_thresh(line_thresh), .phase_dly(phase_dly),
        .position(position), .line_start(line_start), .line_valid(line_valid),
        .tdi_shift(tdi_shift), .line_count(line_count), .dir_rev(dir_rev),
        .quad_err(quad_err), .miss_count(miss_count), .overrun(overrun),
        .idx_seen(idx_seen)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            ls_cnt <= 0; lv_cnt <= 0; ts_cnt <= 0;
        end else begin
            if (line_start) begin ls_cnt <= ls_cnt + 1; ls_cyc <= cyc; end
            if (line_valid) begin lv_cnt <= lv_cnt + 1; lv_prev <= lv_cyc; lv_cyc <= cyc; end
            if (tdi_shift) ts_cnt <= ts_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic [15:0] th, input logic [15:0] d, input logic ie);
        @(negedge clk);
        rst = 1'b1; enc_a = 1'b0; enc_b = 1'b0; enc_z = 1'b0;
        line_thresh = th; phase_dly = d; idx_en = ie;
        idle(3);
        rst = 1'b0;
        idle(2);
    endtask

    task automatic set_ab(input logic a, input logic b);
        @(negedge clk);
        enc_a = a; enc_b = b;
    endtask

    task automatic fwd(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            case ({enc_a, enc_b})
                2'b00: set_ab(1'b0, 1'b1);
                2'b01: set_ab(1'b1, 1'b1);
                2'b11: set_ab(1'b1, 1'b0);
                default: set_ab(1'b0, 1'b0);
            endcase
            idle(gap);
        end
    endtask

    task automatic rev(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            case ({enc_a, enc_b})
                2'b00: set_ab(1'b1, 1'b0);
                2'b10: set_ab(1'b1, 1'b1);
                2'b11: set_ab(1'b0, 1'b1);
                default: set_ab(1'b0, 1'b0);
            endcase
            idle(gap);
        end
    endtask

    task automatic t_reset;
        do_reset(16'd8, 16'd0, 1'b0);
        chk_eq("R10 position", $signed(position), 0);
        chk_eq("R10 line_count", line_count, 0);
        chk_eq("R10 miss_count", miss_count, 0);
        chk_eq("R10 flags", {line_start, line_valid, tdi_shift, dir_rev, quad_err, overrun, idx_seen}, 0);
    endtask

    task automatic t_forward;
        do_reset(16'd8, 16'd3, 1'b0);
        fwd(10, 2);
        idle(10);
        chk_eq("R1 position after 10 fwd", $signed(position), 10);
        chk_eq("R4 one line start", ls_cnt, 1);
        chk_eq("R7 line_valid count", lv_cnt, 1);
        chk_eq("R7 tdi_shift count", ts_cnt, 1);
        chk_eq("R7 delay cycles", lv_cyc - ls_cyc, 4);
        chk_eq("R8 line_count", line_count, 1);
    endtask

    task automatic t_reverse;
        do_reset(16'd4, 16'd0, 1'b0);
        fwd(2, 1);
        rev(3, 1);
        idle(2);
        chk_eq("R2 position", $signed(position), -1);
        chk_eq("R2 dir_rev", dir_rev, 1);
        fwd(4, 1);
        idle(3);
        chk_eq("R5 no line before recovery", ls_cnt, 0);
        chk_eq("R2 dir_rev cleared", dir_rev, 0);
        fwd(1, 1);
        idle(3);
        chk_eq("R5 line after recovery", ls_cnt, 1);
        chk_eq("R1 position", $signed(position), 4);
    endtask

    task automatic t_illegal;
        do_reset(16'd8, 16'd0, 1'b0);
        set_ab(1'b1, 1'b1);
        idle(2);
        chk_eq("R3 position held", $signed(position), 0);
        chk_eq("R3 quad_err", quad_err, 1);
        chk_eq("R3 miss_count", miss_count, 1);
        set_ab(1'b1, 1'b0);
        idle(2);
        chk_eq("R3 legal step after error", $signed(position), 1);
        chk_eq("R3 quad_err sticky", quad_err, 1);
        set_ab(1'b0, 1'b1);
        idle(2);
        chk_eq("R3 miss_count second", miss_count, 2);
    endtask

    task automatic t_index;
        do_reset(16'd8, 16'd0, 1'b1);
        fwd(6, 1);
        idle(2);
        chk_eq("R6 pre-index position", $signed(position), 6);
        chk_eq("R6 idx_seen low", idx_seen, 0);
        @(negedge clk); enc_z = 1'b1;
        idle(2);
        chk_eq("R6 position cleared", $signed(position), 0);
        chk_eq("R6 idx_seen set", idx_seen, 1);
        @(negedge clk); enc_z = 1'b0;
        fwd(4, 1);
        @(negedge clk); enc_z = 1'b1;
        idle(2);
        @(negedge clk); enc_z = 1'b0;
        idle(2);
        chk_eq("R6 second index ignored", $signed(position), 4);
        chk_eq("R6 accumulator cleared", ls_cnt, 0);
        fwd(4, 1);
        idle(3);
        chk_eq("R6 line from cleared count", ls_cnt, 1);
    endtask

    task automatic t_pending;
        do_reset(16'd1, 16'd5, 1'b0);
        fwd(2, 0);
        idle(20);
        chk_eq("R9 two line starts", ls_cnt, 2);
        chk_eq("R9 two line_valid", lv_cnt, 2);
        chk_eq("R9 spacing", lv_cyc - lv_prev, 6);
        chk_eq("R9 overrun", overrun, 1);
        chk_eq("R8 line_count", line_count, 2);
    endtask

    task automatic t_zero_thresh;
        do_reset(16'd0, 16'd0, 1'b0);
        fwd(3, 3);
        idle(4);
        chk_eq("R11 line per step", ls_cnt, 3);
        chk_eq("R11 line_count", line_count, 3);
        chk_eq("R7 zero delay", lv_cyc - ls_cyc, 1);
        chk_eq("R9 no overrun", overrun, 0);
    endtask

    initial begin
        t_reset;
        t_forward;
        t_reverse;
        t_illegal;
        t_index;
        t_pending;
        t_zero_thresh;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule